// File: doc/BRIEF.md
# Descriptor-Walking Bus-Master DMA Engine

This engine moves one command's worth of sector data between a drive buffer and system memory. The command controller first arms it with a transfer direction and a sector count. It then supplies the address of a table of region descriptors. The engine reads descriptors one at a time over a single memory request port, which the memory answers in the same cycle. For each region it waits out a disk latency, then issues data bursts that never straddle a memory page. It chains to the next descriptor until one carries the end-of-table flag.

The engine keeps a running count of the command bytes still owed. It refuses to move more than that count. At end of table it reports done if the count reached zero and error otherwise. A refused memory request is retried after a fixed backoff. An abort from the controller ends the transfer at once with an error. The engine only produces addresses and lengths; the data path itself sits next to it.

Top module: `dma_walker`

## Requirements
- R1: After reset the phase output is idle (0), no memory request is raised, done and err are low and the remaining byte count reads 0.
- R2: An arm pulse while idle moves the phase to started (1) on the next cycle and loads the remaining count with sectors x 512, where a sector field of 0 means 256 sectors.
- R3: A start pulse while started moves the phase to transferring (2) and fetches the first descriptor from the programmed base with bits 1:0 forced to zero. A start pulse in any other phase raises err for one cycle and leaves the engine idle. No memory request is raised outside the transferring phase.
- R4: A descriptor is a 64-bit word. Bits 31:0 hold the region address, bits 47:32 the byte count (0 means 65536), and bit 63 is end-of-table. Bits 62:48 must be zero, or the engine raises err and goes idle. Descriptor requests use kind 0 with length 8, and each fetch advances the table pointer by 8.
- R5: Each data burst length is the smaller of the region bytes left and the bytes up to the next PAGE_BYTES boundary. Bursts of one region are issued in ascending address order.
- R6: When a request is not granted, exactly BACKOFF cycles pass with no request, and then the same request is raised again.
- R7: For a region of N bytes, exactly DISK_LAT + floor(N/512) cycles pass between the cycle its descriptor returns (mem_rvalid high) and the cycle its first burst is raised.
- R8: An armed write-to-disk command issues memory reads (kind 1). A read-from-disk command issues memory writes (kind 2). Kind 3 never appears.
- R9: Each granted burst lowers the remaining count by its length. A burst longer than the remaining count is never issued; instead err pulses and the engine goes idle with the count unchanged.
- R10: After the last burst of an end-of-table region is granted, the next cycle shows done if the count reached zero, and err otherwise. Either way the phase is idle in that cycle.
- R11: After the last burst of a region without end-of-table, the next descriptor is fetched from the following table entry.
- R12: An abort in the started or transferring phase makes the next cycle idle with err high, and no further request follows. An abort while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Controller pulse: accept a new command |
| arm_to_disk | input | 1 | Direction at arm time: 1 = data goes to the disk |
| arm_sectors | input | 8 | Command sector count, 0 = 256 |
| start | input | 1 | Start pulse carrying the table base |
| start_base | input | AW | Descriptor table base (bits 1:0 ignored) |
| abort | input | 1 | Controller pulse: stop the command |
| mem_req | output | 1 | Memory request valid |
| mem_kind | output | 2 | 0 descriptor read, 1 data read, 2 data write |
| mem_addr | output | AW | Request address |
| mem_len | output | 17 | Request length in bytes |
| mem_gnt | input | 1 | Same-cycle grant of the request |
| mem_rvalid | input | 1 | Descriptor word returned |
| mem_rdata | input | 64 | Descriptor word |
| phase | output | 2 | 0 idle, 1 started, 2 transferring |
| left_bytes | output | 18 | Command bytes not yet moved |
| done | output | 1 | One-cycle successful completion |
| err | output | 1 | One-cycle error completion |

## Verification
Arm, start and abort take effect on the following cycle. The bench drives these just after a rising edge and reads phase, count and err at the next falling edge. A done appears exactly one cycle after the final grant, and the bench compares cycle stamps to check this. Retry spacing is BACKOFF+1 cycles from the refused request to its reissue. The first burst of a region comes DISK_LAT + sectors + 1 cycles after the descriptor returns. A falling-edge monitor checks both of these gaps against a free-running cycle counter. It also compares every granted request against a list that the bench derives arithmetically from the descriptor table.

// File: rtl/dma_walker.sv
module dma_walker #(
  parameter int PAGE_BYTES = 8192,
  parameter int DISK_LAT   = 16,
  parameter int BACKOFF    = 4,
  parameter int AW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          arm_to_disk,
  input  logic [7:0]    arm_sectors,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  input  logic          abort,
  output logic          mem_req,
  output logic [1:0]    mem_kind,
  output logic [AW-1:0] mem_addr,
  output logic [16:0]   mem_len,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  output logic [1:0]    phase,
  output logic [17:0]   left_bytes,
  output logic          done,
  output logic          err
);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam int RW = 17;
  localparam int CW = 18;
  localparam int TW = $clog2(DISK_LAT + BACKOFF + 130) + 1;

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_FETCH, S_FWAIT, S_DELAY, S_BURST, S_BACK} st_t;

  st_t           st;
  logic          to_disk, eot, ret_fetch;
  logic [AW-1:0] ptr, cur;
  logic [RW-1:0] rem, blen, d_cnt;
  logic [RW:0]   room;
  logic [TW-1:0] tmr;
  logic [CW-1:0] cmd_bytes;
  logic          fits, last, stop;

  assign room      = (RW+1)'(PAGE_BYTES) - (RW+1)'(cur[PB-1:0]);
  assign blen      = ({1'b0, rem} < room) ? rem : room[RW-1:0];
  assign fits      = CW'(blen) <= left_bytes;
  assign last      = blen == rem;
  assign stop      = abort || start;
  assign d_cnt     = (mem_rdata[47:32] == 16'd0) ? 17'h10000 : {1'b0, mem_rdata[47:32]};
  assign cmd_bytes = (arm_sectors == 8'd0) ? 18'h20000 : {1'b0, arm_sectors, 9'd0};

  assign mem_req  = !stop && (st == S_FETCH || (st == S_BURST && fits));
  assign mem_kind = (st == S_FETCH) ? 2'd0 : (to_disk ? 2'd1 : 2'd2);
  assign mem_addr = (st == S_FETCH) ? ptr : cur;
  assign mem_len  = (st == S_FETCH) ? 17'd8 : blen;
  assign phase    = (st == S_IDLE) ? 2'd0 : (st == S_ARMED) ? 2'd1 : 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      to_disk    <= 1'b0;
      eot        <= 1'b0;
      ret_fetch  <= 1'b0;
      ptr        <= '0;
      cur        <= '0;
      rem        <= '0;
      tmr        <= '0;
      left_bytes <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) err <= 1'b1;
          else if (arm) begin
            st         <= S_ARMED;
            left_bytes <= cmd_bytes;
            to_disk    <= arm_to_disk;
          end
        end
        S_ARMED: begin
          if (abort) begin
            st  <= S_IDLE;
            err <= 1'b1;
          end else if (start) begin
            ptr <= start_base & ~AW'(3);
            st  <= S_FETCH;
          end
        end
        default: begin
          if (stop) begin
            st  <= S_IDLE;
            err <= 1'b1;
          end else begin
            case (st)
              S_FETCH: begin
                if (mem_gnt) begin
                  ptr <= ptr + AW'(8);
                  st  <= S_FWAIT;
                end else begin
                  tmr       <= TW'(BACKOFF - 1);
                  ret_fetch <= 1'b1;
                  st        <= S_BACK;
                end
              end
              S_FWAIT: begin
                if (mem_rvalid) begin
                  if (mem_rdata[62:48] != 15'd0) begin
                    st  <= S_IDLE;
                    err <= 1'b1;
                  end else begin
                    cur <= AW'(mem_rdata[31:0]);
                    rem <= d_cnt;
                    eot <= mem_rdata[63];
                    tmr <= TW'(DISK_LAT - 1) + TW'(d_cnt >> 9);
                    st  <= S_DELAY;
                  end
                end
              end
              S_DELAY: begin
                if (tmr == '0) st <= S_BURST;
                else tmr <= tmr - TW'(1);
              end
              S_BURST: begin
                if (!fits) begin
                  st  <= S_IDLE;
                  err <= 1'b1;
                end else if (mem_gnt) begin
                  left_bytes <= left_bytes - CW'(blen);
                  cur        <= cur + AW'(blen);
                  rem        <= rem - blen;
                  if (last) begin
                    if (eot) begin
                      st <= S_IDLE;
                      if (left_bytes == CW'(blen)) done <= 1'b1;
                      else err <= 1'b1;
                    end else begin
                      st <= S_FETCH;
                    end
                  end
                end else begin
                  tmr       <= TW'(BACKOFF - 1);
                  ret_fetch <= 1'b0;
                  st        <= S_BACK;
                end
              end
              S_BACK: begin
                if (tmr == '0) st <= ret_fetch ? S_FETCH : S_BURST;
                else tmr <= tmr - TW'(1);
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_walker_chk.sv
module dma_walker_chk #(
  parameter int PAGE_BYTES = 8192,
  parameter int AW         = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          mem_req,
  input logic [1:0]    mem_kind,
  input logic [AW-1:0] mem_addr,
  input logic [16:0]   mem_len,
  input logic          mem_gnt,
  input logic [1:0]    phase,
  input logic [17:0]   left_bytes,
  input logic          done,
  input logic          err
);
  localparam int PB = $clog2(PAGE_BYTES);

  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_kind != 2'd0 |-> (32'(mem_addr[PB-1:0]) + 32'(mem_len)) <= 32'(PAGE_BYTES)); // R5
  AST_BURST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_len != 17'd0); // R5
  AST_DESC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_kind == 2'd0 |-> mem_addr[1:0] == 2'b00 && mem_len == 17'd8); // R4
  AST_REQ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> phase == 2'd2); // R3
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_kind != 2'd3); // R8
  AST_REFUSED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> !mem_req); // R6
  AST_LEFT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && mem_kind != 2'd0 |=> left_bytes == $past(left_bytes) - 18'($past(mem_len))); // R9
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> left_bytes == 18'd0 && phase == 2'd0 && !err); // R10
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort && phase != 2'd0 |=> phase == 2'd0 && err); // R12
endmodule

bind dma_walker dma_walker_chk #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .abort(abort), .mem_req(mem_req), .mem_kind(mem_kind),
  .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt), .phase(phase),
  .left_bytes(left_bytes), .done(done), .err(err));

// File: tb/dma_walker_tb_top.sv
module dma_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE  = 1024;
  localparam int LAT   = 3;
  localparam int BO    = 2;
  localparam logic [31:0] TBASE = 32'h0000_4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, arm_to_disk = 1'b0, start = 1'b0, abort = 1'b0;
  logic [7:0] arm_sectors = 8'd0;
  logic [31:0] start_base = 32'd0;
  logic mem_req, mem_gnt, done, err;
  logic [1:0] mem_kind, phase;
  logic [31:0] mem_addr;
  logic [16:0] mem_len;
  logic [17:0] left_bytes;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = 64'd0;
  logic [63:0] desc_mem [16];
  logic refuse_on = 1'b0, pend_retry = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  int exp_kind [256];
  longint exp_addr [256], exp_len [256];
  int exp_n = 0, exp_i = 0;
  bit exp_done;
  longint exp_left;
  bit await_first = 0, ref_pend = 0;
  int rv_cyc, ref_cyc, want_delay, last_gnt_cyc;
  logic [31:0] ref_addr;

  dma_walker #(.PAGE_BYTES(PAGE), .DISK_LAT(LAT), .BACKOFF(BO), .AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .arm_to_disk(arm_to_disk), .arm_sectors(arm_sectors),
    .start(start), .start_base(start_base), .abort(abort), .mem_req(mem_req), .mem_kind(mem_kind),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .phase(phase), .left_bytes(left_bytes), .done(done), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_gnt = mem_req && (!refuse_on || pend_retry);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) pend_retry <= 1'b0;
    else if (mem_req) pend_retry <= !mem_gnt;
    mem_rvalid <= rst_n && mem_req && mem_gnt && mem_kind == 2'd0;
    mem_rdata  <= desc_mem[4'((mem_addr - TBASE) >> 3)];
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rvalid) begin
        want_delay = LAT + ((mem_rdata[47:32] == 16'd0) ? 65536 : int'(mem_rdata[47:32])) / 512;
        rv_cyc = cyc;
        await_first = 1;
      end
      if (mem_req) begin
        if (ref_pend) begin
          chk(cyc - ref_cyc == BO + 1, "R6 retry gap", cyc - ref_cyc, BO + 1);
          chk(mem_addr == ref_addr, "R6 retry address", mem_addr, ref_addr);
          ref_pend = 0;
        end
        if (await_first && mem_kind != 2'd0) begin
          chk(cyc - rv_cyc == want_delay + 1, "R7 disk latency", cyc - rv_cyc, want_delay + 1);
          await_first = 0;
        end
        if (mem_gnt) begin
          if (exp_i < exp_n) begin
            chk(mem_kind == exp_kind[exp_i], "R8 request kind", mem_kind, exp_kind[exp_i]);
            chk(mem_addr == exp_addr[exp_i], exp_kind[exp_i] == 0 ? "R4 descriptor address" : "R5 burst address",
                mem_addr, exp_addr[exp_i]);
            chk(mem_len == exp_len[exp_i], exp_kind[exp_i] == 0 ? "R4 descriptor length" : "R5 burst length",
                mem_len, exp_len[exp_i]);
          end else begin
            chk(1'b0, "R9 unexpected request", exp_i, exp_n);
          end
          exp_i++;
          last_gnt_cyc = cyc;
        end else begin
          ref_pend = 1;
          ref_cyc  = cyc;
          ref_addr = mem_addr;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input int k, input longint a, input longint l);
    exp_kind[exp_n] = k;
    exp_addr[exp_n] = a;
    exp_len[exp_n]  = l;
    exp_n++;
  endtask

  task automatic plan(input bit td, input logic [7:0] sec, input int nd);
    longint left, a, rem, room, l;
    bit stp;
    exp_n = 0;
    exp_done = 0;
    stp = 0;
    left = (sec == 8'd0) ? 131072 : longint'(sec) * 512;
    for (int i = 0; i < nd && !stp; i++) begin
      push(0, TBASE + 8 * i, 8);
      if (desc_mem[i][62:48] != 15'd0) begin
        stp = 1;
      end else begin
        a = desc_mem[i][31:0];
        rem = (desc_mem[i][47:32] == 16'd0) ? 65536 : longint'(desc_mem[i][47:32]);
        while (rem > 0 && !stp) begin
          room = PAGE - (a % PAGE);
          l = (rem < room) ? rem : room;
          if (l > left) stp = 1;
          else begin
            push(td ? 1 : 2, a, l);
            left -= l;
            a += l;
            rem -= l;
          end
        end
        if (!stp && desc_mem[i][63]) begin
          stp = 1;
          exp_done = (left == 0);
        end
      end
    end
    exp_left = left;
  endtask

  task automatic arm_cmd(input bit td, input logic [7:0] sec);
    tick();
    arm = 1'b1; arm_to_disk = td; arm_sectors = sec;
    tick();
    arm = 1'b0;
    @(negedge clk);
    chk(phase == 2'd1, "R2 phase after arm", phase, 1);
    chk(left_bytes == ((sec == 8'd0) ? 18'd131072 : 18'(sec) * 18'd512), "R2 loaded count",
        left_bytes, (sec == 8'd0) ? 131072 : sec * 512);
  endtask

  task automatic run_case(input bit td, input logic [7:0] sec, input logic [31:0] bprog,
                          input bit refuse, input int nd, input string tag);
    int t;
    plan(td, sec, nd);
    exp_i = 0; await_first = 0; ref_pend = 0;
    refuse_on = refuse;
    arm_cmd(td, sec);
    tick();
    start = 1'b1; start_base = bprog;
    tick();
    start = 1'b0;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!(done || err) && t < 20000);
    if (exp_done) begin
      chk(done == 1'b1, {tag, " done"}, done, 1);
      chk(cyc == last_gnt_cyc + 1, "R10 done timing", cyc, last_gnt_cyc + 1);
    end else begin
      chk(err == 1'b1 && done == 1'b0, {tag, " error"}, err, 1);
    end
    chk(exp_i == exp_n, {tag, " request count"}, exp_i, exp_n);
    chk(left_bytes == exp_left, "R9 final count", left_bytes, exp_left);
    chk(phase == 2'd0, "R10 idle at end", phase, 0);
    refuse_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) desc_mem[i] = 64'd0;
    repeat (3) tick();
    @(negedge clk);
    chk(phase == 2'd0, "R1 reset phase", phase, 0);
    chk(mem_req == 1'b0, "R1 reset request", mem_req, 0);
    chk(done == 1'b0 && err == 1'b0, "R1 reset flags", {done, err}, 0);
    chk(left_bytes == 18'd0, "R1 reset count", left_bytes, 0);
    tick();
    rst_n = 1'b1;

    tick(); start = 1'b1; tick(); start = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R3 start while idle", err, 1);
    chk(phase == 2'd0, "R3 idle after bad start", phase, 0);

    tick(); abort = 1'b1; tick(); abort = 1'b0;
    @(negedge clk);
    chk(err == 1'b0 && phase == 2'd0, "R12 abort ignored when idle", err, 0);

    arm_cmd(1'b0, 8'd0);
    tick(); abort = 1'b1; tick(); abort = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R12 abort while started", err, 1);
    chk(phase == 2'd0, "R12 idle after abort", phase, 0);

    for (int d = 0; d < 2; d++) begin
      for (int oi = 0; oi < 4; oi++) begin
        for (int si = 0; si < 4; si++) begin
          logic [7:0] sec;
          logic [31:0] base;
          sec  = (si == 3) ? 8'd5 : 8'(si + 1);
          base = 32'h0010_0000 + 32'(si) * 32'h2000 + 32'(oi) * 32'd331;
          desc_mem[0] = {1'b1, 15'd0, 16'(int'(sec) * 512), base};
          run_case(d[0], sec, TBASE | 32'(oi), 1'b0, 1, "R5");
        end
      end
    end

    for (int d = 0; d < 2; d++) begin
      desc_mem[0] = {1'b0, 15'd0, 16'd1000, 32'h0040_0300};
      desc_mem[1] = {1'b0, 15'd0, 16'd700,  32'h0050_03F0};
      desc_mem[2] = {1'b1, 15'd0, 16'd348,  32'h0060_0000};
      run_case(d[0], 8'd4, TBASE, 1'b1, 3, "R11");
    end

    desc_mem[0] = {1'b1, 15'd0, 16'd0, 32'h0020_0100};
    run_case(1'b1, 8'd128, TBASE, 1'b0, 1, "R4 zero count");

    desc_mem[0] = {1'b1, 15'd0, 16'd1024, 32'h0003_0300};
    run_case(1'b0, 8'd1, TBASE, 1'b0, 1, "R9 overrun");

    desc_mem[0] = {1'b1, 15'd0, 16'd1024, 32'h0003_0000};
    run_case(1'b1, 8'd4, TBASE, 1'b1, 1, "R10 leftover");

    desc_mem[0] = {1'b1, 15'h0004, 16'd512, 32'h0007_0000};
    run_case(1'b0, 8'd1, TBASE, 1'b0, 1, "R4 reserved bits");

    desc_mem[0] = {1'b1, 15'd0, 16'd0, 32'h0008_0000};
    plan(1'b0, 8'd128, 1);
    exp_i = 0; await_first = 0; ref_pend = 0;
    arm_cmd(1'b0, 8'd128);
    tick(); start = 1'b1; start_base = TBASE; tick(); start = 1'b0;
    repeat (40) tick();
    abort = 1'b1; tick(); abort = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R12 abort while transferring", err, 1);
    chk(phase == 2'd0, "R12 idle after transfer abort", phase, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_req) chk(1'b0, "R12 request after abort", mem_req, 0);
    end
    chk(exp_i == 1, "R12 only the descriptor was fetched", exp_i, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule